// File: doc/BRIEF.md
# Wavefront Instruction Fetch Arbiter

The block watches a fixed number of wavefront slots and decides, at most once per clock, which slot may start an instruction fetch. Each slot supplies four status inputs: whether it is running, how many entries its instruction buffer holds, whether a branch is waiting in that buffer, and (tracked inside the block) whether a fetch is already in flight for it. A slot that is free to fetch joins a ready queue. The arbiter serves that queue oldest-first, emits a one-cycle start pulse with the slot id, and marks the slot as having a fetch in flight.

The block also takes fetch completions. For each completion it either discards the returned words, when the slot's discard flag was armed by `drop_req`, or reports how many instructions the slot's buffer should accept. The in-flight mark is removed either way. A completion for a slot with nothing in flight raises a protocol error pulse and has no other effect. Address generation, translation, memory access and decode sit outside this block.

Top module: `wf_fetch_arbiter`

## Requirements
- R1: A slot is eligible when it is running, its buffer occupancy is at most OCC_LIMIT (4), it has no branch buffered, it has no fetch in flight and it is not already queued. An occupancy of exactly 4 is eligible and an occupancy of 5 is not.
- R2: With an empty queue, a slot that is eligible in cycle t produces `fetch_start` = 1 and `fetch_slot` = its index in cycle t+1. At most one start occurs per cycle, and none occurs when nothing is queued.
- R3: The queue is served oldest-first. Slots that become eligible in the same cycle are queued in ascending index order, so slot 0 is started before slot 7.
- R4: A queued slot is not re-evaluated. It is started in its turn even if its status inputs stop qualifying after it was queued.
- R5: Starting a slot marks it as having a fetch in flight. It is not started again until a completion for it arrives.
- R6: A completion (`ret_valid`) for an in-flight slot whose discard flag is set gives `drop_done` = 1 the next cycle, with no push, and clears the discard flag. `drop_req[i]` = 1 arms the flag of slot i. The slot's buffer occupancy must be 0 when the completion arrives.
- R7: A completion for an in-flight slot whose discard flag is clear gives `push_valid` = 1 the next cycle, with `push_slot` = the slot and `push_count` = `ret_bytes` / INST_BYTES (8). The slot's occupancy must be at most 4 when the completion arrives.
- R8: Every completion for an in-flight slot clears its in-flight mark, whether or not the data was discarded. A slot that is still eligible can then be started again.
- R9: A completion for a slot with no fetch in flight gives `proto_err` = 1 the next cycle, with no push and no `drop_done`. At most one of `push_valid`, `drop_done` and `proto_err` is high in any cycle.
- R10: After reset every output pulse is 0, nothing is queued or in flight, and no discard flag is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_running | input | N_SLOTS | Slot i is running |
| slot_occ | input | N_SLOTS*OCC_W | Buffer occupancy of slot i in bits [i*OCC_W +: OCC_W] |
| slot_has_branch | input | N_SLOTS | Slot i has a branch buffered |
| drop_req | input | N_SLOTS | Arm the discard flag of slot i |
| ret_valid | input | 1 | A fetch completion is presented |
| ret_slot | input | SLOT_W | Slot of the completion |
| ret_bytes | input | BYTES_W | Byte count returned |
| fetch_start | output | 1 | One-cycle pulse: start a fetch |
| fetch_slot | output | SLOT_W | Slot being started |
| push_valid | output | 1 | Push returned instructions |
| push_slot | output | SLOT_W | Slot receiving the push |
| push_count | output | BYTES_W-log2(INST_BYTES) | Number of instructions to push |
| drop_done | output | 1 | Completion discarded |
| proto_err | output | 1 | Completion for a slot with nothing in flight |

## Verification
Every output is registered. A start is due one cycle after the cycle in which the slot first qualifies, provided the queue was empty. If the queue was not empty, the start comes one cycle later for each older entry still waiting. Completion results are due exactly one cycle after `ret_valid`. The bench drives inputs after the falling edge and advances a reference model of queue, in-flight and discard state by one step for those inputs. It then compares every output at the next falling edge, one rising edge later, so that each expectation lands on the cycle where the result is due.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_PUSH = 2'd1,
        RET_DROP = 2'd2,
        RET_ERR  = 2'd3
    } ret_kind_e;

endpackage

// File: rtl/wfa_elig.sv
module wfa_elig #(
    parameter int N_SLOTS   = 8,
    parameter int OCC_W     = 4,
    parameter int OCC_LIMIT = 4
) (
    input  logic [N_SLOTS-1:0]       running,
    input  logic [N_SLOTS*OCC_W-1:0] occ,
    input  logic [N_SLOTS-1:0]       has_branch,
    input  logic [N_SLOTS-1:0]       outst_q,
    input  logic [N_SLOTS-1:0]       queued_q,
    output logic [N_SLOTS-1:0]       elig
);
    localparam logic [OCC_W-1:0] LIMIT = OCC_W'(OCC_LIMIT);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic room;
        assign room    = occ[g*OCC_W +: OCC_W] <= LIMIT;
        assign elig[g] = running[g] & room & ~has_branch[g] & ~outst_q[g] & ~queued_q[g];
    end
endmodule

// File: rtl/wfa_ready_q.sv
module wfa_ready_q #(
    parameter int N_SLOTS = 8,
    parameter int SLOT_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SLOTS-1:0]  push_vec,
    output logic                head_valid,
    output logic [SLOT_W-1:0]   head_id
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N_SLOTS - 1);

    typedef struct packed {
        logic [N_SLOTS-1:0][SLOT_W-1:0] ent;
        logic [SLOT_W-1:0]              rd;
        logic [SLOT_W-1:0]              wr;
        logic [SLOT_W:0]                cnt;
    } q_st_t;

    q_st_t st_d, st_q;

    always_comb begin
        logic [SLOT_W-1:0] idx;
        logic [SLOT_W:0]   n_push;
        logic [SLOT_W:0]   total;
        st_d   = st_q;
        idx    = st_q.wr;
        n_push = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (push_vec[i]) begin
                st_d.ent[idx] = SLOT_W'(i);
                idx           = (idx == LAST) ? '0 : idx + 1'b1;
                n_push        = n_push + 1'b1;
            end
        end
        st_d.wr    = idx;
        total      = st_q.cnt + n_push;
        head_valid = total != '0;
        head_id    = st_d.ent[st_q.rd];
        if (head_valid) begin
            st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = total - {{SLOT_W{1'b0}}, head_valid};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wfa_ret.sv
module wfa_ret
    import wfa_pkg::*;
#(
    parameter int N_SLOTS  = 8,
    parameter int SLOT_W   = 3,
    parameter int BYTES_W  = 8,
    parameter int IB_SHIFT = 3
) (
    input  logic                      ret_valid,
    input  logic [SLOT_W-1:0]         ret_slot,
    input  logic [BYTES_W-1:0]        ret_bytes,
    input  logic [N_SLOTS-1:0]        outst_q,
    input  logic [N_SLOTS-1:0]        drop_q,
    output ret_kind_e                 kind,
    output logic [N_SLOTS-1:0]        clr_vec,
    output logic [BYTES_W-IB_SHIFT-1:0] count
);
    always_comb begin
        kind    = RET_NONE;
        clr_vec = '0;
        count   = ret_bytes[BYTES_W-1:IB_SHIFT];
        if (ret_valid) begin
            if (!outst_q[ret_slot]) begin
                kind = RET_ERR;
            end else begin
                clr_vec[ret_slot] = 1'b1;
                kind = drop_q[ret_slot] ? RET_DROP : RET_PUSH;
            end
        end
    end
endmodule

// File: rtl/wf_fetch_arbiter.sv
module wf_fetch_arbiter
    import wfa_pkg::*;
#(
    parameter int N_SLOTS    = 8,
    parameter int OCC_W      = 4,
    parameter int OCC_LIMIT  = 4,
    parameter int BYTES_W    = 8,
    parameter int INST_BYTES = 8,
    localparam int SLOT_W    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int IB_SHIFT  = $clog2(INST_BYTES),
    localparam int CNT_W     = BYTES_W - IB_SHIFT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_SLOTS-1:0]         slot_running,
    input  logic [N_SLOTS*OCC_W-1:0]   slot_occ,
    input  logic [N_SLOTS-1:0]         slot_has_branch,
    input  logic [N_SLOTS-1:0]         drop_req,
    input  logic                       ret_valid,
    input  logic [SLOT_W-1:0]          ret_slot,
    input  logic [BYTES_W-1:0]         ret_bytes,
    output logic                       fetch_start,
    output logic [SLOT_W-1:0]          fetch_slot,
    output logic                       push_valid,
    output logic [SLOT_W-1:0]          push_slot,
    output logic [CNT_W-1:0]           push_count,
    output logic                       drop_done,
    output logic                       proto_err
);
    typedef struct packed {
        logic [N_SLOTS-1:0] queued;
        logic [N_SLOTS-1:0] outst;
        logic [N_SLOTS-1:0] drop;
        logic               fetch_start;
        logic [SLOT_W-1:0]  fetch_slot;
        logic               push_valid;
        logic [SLOT_W-1:0]  push_slot;
        logic [CNT_W-1:0]   push_count;
        logic               drop_done;
        logic               proto_err;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [N_SLOTS-1:0] elig;
    logic               head_valid;
    logic [SLOT_W-1:0]  head_id;
    ret_kind_e          ret_kind;
    logic [N_SLOTS-1:0] ret_clr;
    logic [CNT_W-1:0]   ret_count;
    logic [N_SLOTS-1:0] outst_vec;
    logic [N_SLOTS-1:0] drop_vec;

    wfa_elig #(.N_SLOTS(N_SLOTS), .OCC_W(OCC_W), .OCC_LIMIT(OCC_LIMIT)) elig_i (
        .running    (slot_running),
        .occ        (slot_occ),
        .has_branch (slot_has_branch),
        .outst_q    (st_q.outst),
        .queued_q   (st_q.queued),
        .elig       (elig)
    );

    wfa_ready_q #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) ready_q_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_vec   (elig),
        .head_valid (head_valid),
        .head_id    (head_id)
    );

    wfa_ret #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .BYTES_W(BYTES_W), .IB_SHIFT(IB_SHIFT)) ret_i (
        .ret_valid (ret_valid),
        .ret_slot  (ret_slot),
        .ret_bytes (ret_bytes),
        .outst_q   (st_q.outst),
        .drop_q    (st_q.drop),
        .kind      (ret_kind),
        .clr_vec   (ret_clr),
        .count     (ret_count)
    );

    always_comb begin
        st_d             = st_q;
        st_d.fetch_start = 1'b0;
        st_d.push_valid  = 1'b0;
        st_d.drop_done   = 1'b0;
        st_d.proto_err   = 1'b0;

        st_d.queued = st_q.queued | elig;
        st_d.outst  = st_q.outst & ~ret_clr;
        st_d.drop   = (st_q.drop & ~ret_clr) | drop_req;

        if (head_valid) begin
            st_d.queued[head_id] = 1'b0;
            st_d.outst[head_id]  = 1'b1;
            st_d.fetch_start     = 1'b1;
            st_d.fetch_slot      = head_id;
        end

        unique case (ret_kind)
            RET_PUSH: begin
                st_d.push_valid = 1'b1;
                st_d.push_slot  = ret_slot;
                st_d.push_count = ret_count;
            end
            RET_DROP: st_d.drop_done = 1'b1;
            RET_ERR:  st_d.proto_err = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_start = st_q.fetch_start;
    assign fetch_slot  = st_q.fetch_slot;
    assign push_valid  = st_q.push_valid;
    assign push_slot   = st_q.push_slot;
    assign push_count  = st_q.push_count;
    assign drop_done   = st_q.drop_done;
    assign proto_err   = st_q.proto_err;
    assign outst_vec   = st_q.outst;
    assign drop_vec    = st_q.drop;
endmodule

// File: rtl/wf_fetch_arbiter_chk.sv
module wf_fetch_arbiter_chk #(
    parameter int N_SLOTS   = 8,
    parameter int OCC_W     = 4,
    parameter int OCC_LIMIT = 4,
    parameter int BYTES_W   = 8,
    parameter int SLOT_W    = 3,
    parameter int IB_SHIFT  = 3,
    parameter int CNT_W     = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_SLOTS*OCC_W-1:0] slot_occ,
    input logic                     ret_valid,
    input logic [SLOT_W-1:0]        ret_slot,
    input logic [BYTES_W-1:0]       ret_bytes,
    input logic                     fetch_start,
    input logic [SLOT_W-1:0]        fetch_slot,
    input logic                     push_valid,
    input logic [CNT_W-1:0]         push_count,
    input logic                     drop_done,
    input logic                     proto_err,
    input logic [N_SLOTS-1:0]       outst_vec,
    input logic [N_SLOTS-1:0]       drop_vec
);
    logic ret_live;
    logic ret_armed;
    logic [OCC_W-1:0] ret_occ;
    assign ret_live  = ret_valid && outst_vec[ret_slot];
    assign ret_armed = drop_vec[ret_slot];
    assign ret_occ   = slot_occ[ret_slot*OCC_W +: OCC_W];

    AST_START_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |-> ((($past(outst_vec) >> fetch_slot) & N_SLOTS'(1)) == '0)); // R5

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_valid, drop_done, proto_err})); // R9

    AST_ERR_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !outst_vec[ret_slot]) |=> proto_err); // R9

    AST_DROP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_live && ret_armed) |=> (drop_done && !push_valid)); // R6

    AST_DROP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_live && ret_armed) |-> (ret_occ == '0)); // R6

    AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_live && !ret_armed) |=> (push_valid && push_count == CNT_W'($past(ret_bytes) >> IB_SHIFT))); // R7

    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_live && !ret_armed) |-> (ret_occ <= OCC_W'(OCC_LIMIT))); // R7

    AST_OUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ret_live |=> (((outst_vec >> $past(ret_slot)) & N_SLOTS'(1)) == '0)); // R8
endmodule

bind wf_fetch_arbiter wf_fetch_arbiter_chk #(
    .N_SLOTS(N_SLOTS), .OCC_W(OCC_W), .OCC_LIMIT(OCC_LIMIT), .BYTES_W(BYTES_W),
    .SLOT_W(SLOT_W), .IB_SHIFT(IB_SHIFT), .CNT_W(CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_occ    (slot_occ),
    .ret_valid   (ret_valid),
    .ret_slot    (ret_slot),
    .ret_bytes   (ret_bytes),
    .fetch_start (fetch_start),
    .fetch_slot  (fetch_slot),
    .push_valid  (push_valid),
    .push_count  (push_count),
    .drop_done   (drop_done),
    .proto_err   (proto_err),
    .outst_vec   (outst_vec),
    .drop_vec    (drop_vec)
);

// File: tb/wf_fetch_arbiter_tb_top.sv
module wf_fetch_arbiter_tb_top;
    localparam int N  = 8;
    localparam int OW = 4;
    localparam int BW = 8;
    localparam int SW = 3;
    localparam int CW = 5;
    localparam int LIMIT = 4;
    localparam int IB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    run = '0, br = '0, dreq = '0;
    logic [N*OW-1:0] occ = '0;
    logic            rv = 1'b0;
    logic [SW-1:0]   rs = '0;
    logic [BW-1:0]   rb = '0;

    logic          fetch_start, push_valid, drop_done, proto_err;
    logic [SW-1:0] fetch_slot, push_slot;
    logic [CW-1:0] push_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit m_q[N];
    bit m_out[N];
    bit m_drop[N];
    int mfifo[$];
    int e_start, e_fslot, e_push, e_pslot, e_pcnt, e_drop, e_err;

    always #2 clk = ~clk;

    wf_fetch_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .slot_running(run), .slot_occ(occ),
        .slot_has_branch(br), .drop_req(dreq), .ret_valid(rv), .ret_slot(rs),
        .ret_bytes(rb), .fetch_start(fetch_start), .fetch_slot(fetch_slot),
        .push_valid(push_valid), .push_slot(push_slot), .push_count(push_count),
        .drop_done(drop_done), .proto_err(proto_err)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int occ_of(int i);
        return int'(occ[i*OW +: OW]);
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_q[i] = 0; m_out[i] = 0; m_drop[i] = 0;
        end
        mfifo.delete();
    endfunction

    function automatic void model_step();
        int sel;
        e_start = 0; e_fslot = 0; e_push = 0; e_pslot = 0; e_pcnt = 0; e_drop = 0; e_err = 0;
        for (int i = 0; i < N; i++) begin
            if (run[i] && occ_of(i) <= LIMIT && !br[i] && !m_out[i] && !m_q[i]) begin
                mfifo.push_back(i);
                m_q[i] = 1;
            end
        end
        sel = -1;
        if (mfifo.size() > 0) begin
            sel = mfifo.pop_front();
            m_q[sel] = 0;
            e_start = 1;
            e_fslot = sel;
        end
        if (rv) begin
            if (!m_out[rs]) e_err = 1;
            else begin
                if (m_drop[rs]) begin
                    e_drop = 1;
                end else begin
                    e_push = 1; e_pslot = int'(rs); e_pcnt = int'(rb) / IB;
                end
                m_out[rs] = 0;
                m_drop[rs] = 0;
            end
        end
        if (sel >= 0) m_out[sel] = 1;
        for (int i = 0; i < N; i++) if (dreq[i]) m_drop[i] = 1;
    endfunction

    task automatic cycle(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "fetch_start", int'(fetch_start), e_start);
        if (e_start != 0) chk(tag, "fetch_slot", int'(fetch_slot), e_fslot);
        chk(tag, "push_valid", int'(push_valid), e_push);
        if (e_push != 0) begin
            chk(tag, "push_slot", int'(push_slot), e_pslot);
            chk(tag, "push_count", int'(push_count), e_pcnt);
        end
        chk(tag, "drop_done", int'(drop_done), e_drop);
        chk(tag, "proto_err", int'(proto_err), e_err);
    endtask

    task automatic set_slot(int i, bit r, int o, bit b);
        run[i] = r;
        occ[i*OW +: OW] = OW'(o);
        br[i] = b;
    endtask

    task automatic give_ret(string tag, int s, int bytes);
        rv = 1'b1; rs = SW'(s); rb = BW'(bytes);
        cycle(tag);
        rv = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "fetch_start", int'(fetch_start), 0);
        chk("R10", "push_valid", int'(push_valid), 0);
        chk("R10", "drop_done", int'(drop_done), 0);
        chk("R10", "proto_err", int'(proto_err), 0);
        rst_n = 1'b1;
        cycle("R10");

        // R1: each disqualifier alone, occupancy boundary 4 vs 5
        set_slot(0, 1, 5, 0); cycle("R1"); cycle("R1");
        set_slot(0, 1, 4, 1); cycle("R1");
        set_slot(0, 0, 4, 0); cycle("R1");
        set_slot(0, 1, 4, 0); cycle("R1");
        // R5: stays qualified, but in flight: no second start
        cycle("R5"); cycle("R5"); cycle("R5");

        // R7: normal return, 24 bytes -> 3 instructions
        give_ret("R7", 0, 24);
        // R8: in-flight cleared, slot restarts
        cycle("R8"); cycle("R8");
        set_slot(0, 0, 0, 0);

        // R6: arm discard, then return with empty buffer
        dreq[0] = 1'b1; cycle("R6"); dreq[0] = 1'b0;
        give_ret("R6", 0, 32);
        cycle("R6");

        // R9: completion for idle slot
        give_ret("R9", 3, 16);
        cycle("R9");

        // R2/R3: all slots qualify at once, served in index order
        for (int i = 0; i < N; i++) set_slot(i, 1, 0, 0);
        cycle("R2");
        for (int i = 0; i < N; i++) cycle("R3");
        cycle("R2");
        for (int i = 0; i < N; i++) set_slot(i, 0, 0, 0);

        // R4: two slots queued together, the later one loses its status
        give_ret("R8", 2, 8);
        give_ret("R8", 6, 8);
        set_slot(2, 1, 0, 0); set_slot(6, 1, 0, 0);
        cycle("R4");
        set_slot(2, 0, 0, 0); set_slot(6, 0, 0, 0);
        cycle("R4"); cycle("R4");

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            int s;
            for (int i = 0; i < N; i++) begin
                run[i] = ($urandom_range(0, 3) != 0);
                occ[i*OW +: OW] = OW'($urandom_range(0, 7));
                br[i] = ($urandom_range(0, 5) == 0);
                dreq[i] = ($urandom_range(0, 19) == 0);
            end
            rv = ($urandom_range(0, 1) == 1);
            s = $urandom_range(0, N - 1);
            rs = SW'(s);
            rb = BW'($urandom_range(0, 255));
            if (rv && m_out[s]) begin
                if (m_drop[s]) occ[s*OW +: OW] = '0;
                else occ[s*OW +: OW] = OW'($urandom_range(0, LIMIT));
            end
            cycle("R3");
        end
        rv = 1'b0; dreq = '0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule